// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and it keeps the memory refreshed afterwards. Right after reset it holds a long idle pause on the bus with clock-enable and the data mask high. It then precharges every bank at once, loads the mode register from a value given at its input, and issues a fixed number of auto-refresh commands. Each command is followed by a recovery gap of NOP cycles. When that sequence is complete it raises a done flag.

In normal operation a free-running interval counter raises a refresh request once per refresh period. An external arbiter, which owns the bus for reads and writes, answers with a grant. The sequencer then places one auto-refresh on its command pins and withdraws the request. Every delay is a parameter counted in clock cycles. The defaults fit a 100 MHz clock: a 200 µs pause and a 15.6 µs average refresh interval, which gives 4096 refreshes in 64 ms.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: The pause lasts PAUSE_CYC cycles, counting the first cycle seen in reset. Every pause cycle carries NOP (chip-select low; row strobe, column strobe and write-enable high) with the address and bank lines at zero.
- R2: The cycle after the pause carries one precharge with chip-select, row strobe and write-enable low and column strobe high. Address bit 10 is high and all other address and bank bits are zero. TRP_CYC NOP cycles follow it.
- R3: After the precharge gap comes one mode-set cycle, with all four strobes low, the address lines equal to `mode_val` and the bank lines zero. A mode-set never appears once `init_done` is high.
- R4: The mode-set is followed by MRD_CYC NOP cycles, and MRD_CYC is at least one.
- R5: After that gap come INIT_REFS auto-refresh commands. Each one has chip-select, row strobe and column strobe low with write-enable high, and each is followed by TRC_CYC NOP cycles.
- R6: `init_done` stays low until the last recovery gap of the start-up refreshes ends and rises in the next cycle. It stays high until reset. `dqm` is high exactly while `init_done` is low.
- R7: `cke` is high in every cycle, including reset.
- R8: `ref_req` first rises REF_INTERVAL cycles after `init_done` rises, and it is set again every REF_INTERVAL cycles after that.
- R9: In normal operation, a refresh appears on the bus only in the cycle after a clock edge at which the block was idle with both `ref_req` and `ref_grant` high. TRC_CYC NOP cycles follow it before another grant can be taken.
- R10: `ref_req` falls in the cycle after its refresh is on the bus, unless an interval expires at that same edge, in which case it stays high.
- R11: `ref_grant` has no effect during start-up or while `ref_req` is low. In those cycles the bus carries whatever the sequence above dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; restarts the whole start-up sequence |
| mode_val | input | ADDR_W | Value driven onto the address lines during the mode-set cycle |
| ref_grant | input | 1 | Arbiter permission to issue the pending refresh |
| sd_cs_n | output | 1 | Chip-select strobe |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write-enable strobe |
| sd_cke | output | 1 | Clock enable, held high |
| sd_dqm | output | 1 | Data mask, high until start-up is complete |
| sd_ba | output | BANK_W | Bank select lines |
| sd_addr | output | ADDR_W | Address lines; bit 10 selects all banks during precharge |
| init_done | output | 1 | Start-up sequence finished |
| ref_req | output | 1 | A periodic refresh is waiting for a grant |

## Verification
The assertions assume that the recovery parameters TRP_CYC, MRD_CYC and TRC_CYC are each at least one, so that every command is followed by a NOP. They also assume that `mode_val` is held steady around the mode-set cycle. The stimulus changes `mode_val` only while reset is held. It moves `ref_grant` only at falling clock edges: held high for long stretches, pulsed during start-up, and withheld for longer than an interval so that an unserved request meets a second interval expiry. A second reset in the middle of operation, with a different mode value, checks that the whole sequence restarts from the pause.

// File: rtl/sdram_seq_pkg.sv
// Shared encodings for the SDRAM start-up and refresh sequencer.
// The command enum packs {cs_n, ras_n, cas_n, we_n} into four bits.
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_PAUSE,   // power-up wait
        ST_PRE,     // precharge-all issue
        ST_TRP,     // precharge recovery
        ST_MRS,     // mode-set issue
        ST_MRD,     // mode-set recovery
        ST_IREF,    // start-up refresh issue
        ST_ITRC,    // start-up refresh recovery
        ST_IDLE,    // normal operation, waiting
        ST_REF,     // periodic refresh issue
        ST_TRC      // periodic refresh recovery
    } seq_state_e;

endpackage

// File: rtl/seq_phase_timer.sv
// Phase timer: counts the cycles spent in the current sequencer phase.
// Assumes: the owner changes phase exactly when phase_last is high, so the
// count restarts from zero on every phase change.
module seq_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] last_val,
    output logic             phase_last
);

    logic [CNT_W-1:0] cnt;

    assign phase_last = (cnt == last_val);

    // Count up within a phase; clear on the final cycle of the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // The count must never run past the limit of the current phase.
    assert_cnt_in_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_val);

endmodule

// File: rtl/refresh_interval_timer.sv
// Refresh interval timer: raises a request once every REF_INTERVAL cycles
// while run is high. The request is dropped when issue reports that a
// refresh is on the bus, except when a new interval expires at that edge.
// Assumes: run stays high once normal operation has started.
module refresh_interval_timer #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic issue,
    output logic ref_req
);

    localparam int IVL_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

    logic [IVL_W-1:0] ivl;
    logic             tick;

    assign tick = run && (ivl == IVL_W'(REF_INTERVAL - 1));

    // Interval counter: idle at zero until run, then wraps every interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            ivl <= '0;
        end else begin
            ivl <= ivl + 1'b1;
        end
    end

    // Request flag: set on expiry, cleared on issue; expiry wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_req <= 1'b0;
        end else if (tick) begin
            ref_req <= 1'b1;
        end else if (issue) begin
            ref_req <= 1'b0;
        end
    end

    assert_req_drops_on_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_req) |-> $past(issue));

    assert_req_only_when_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req) |-> $past(run));

endmodule

// File: rtl/sdram_cmd_encode.sv
// Command encoder: maps the sequencer phase onto the SDRAM command pins.
// Assumes: ADDR_W > PRE_ALL_BIT; mode_val is stable while in ST_MRS.
module sdram_cmd_encode
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int BANK_W      = 1,
    parameter int PRE_ALL_BIT = 10
) (
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] mode_val,
    output sdram_cmd_e        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    // Decode the phase into a command word and its address/bank operands.
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state)
            ST_PRE: begin
                cmd               = CMD_PRE;
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = mode_val;
            end
            ST_IREF, ST_REF: cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_init_refresh_seq.sv
// SDRAM start-up and refresh sequencer (top).
// Runs pause -> precharge-all -> mode-set -> INIT_REFS refreshes, each
// followed by its NOP recovery gap, then raises init_done and serves
// periodic refresh requests through a request/grant handshake.
// Assumes: TRP_CYC, MRD_CYC and TRC_CYC are at least 1; PAUSE_CYC and
// INIT_REFS are at least 1; an external arbiter owns the bus whenever
// this block shows NOP in normal operation.
module sdram_init_refresh_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int BANK_W       = 1,
    parameter int PAUSE_CYC    = 20000,
    parameter int TRP_CYC      = 3,
    parameter int MRD_CYC      = 2,
    parameter int TRC_CYC      = 7,
    parameter int INIT_REFS    = 8,
    parameter int REF_INTERVAL = 1560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_val,
    input  logic              ref_grant,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_cke,
    output logic              sd_dqm,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done,
    output logic              ref_req
);

    localparam int MAX_A   = (PAUSE_CYC > TRP_CYC) ? PAUSE_CYC : TRP_CYC;
    localparam int MAX_B   = (MRD_CYC > TRC_CYC) ? MRD_CYC : TRC_CYC;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);
    localparam int REFN_W  = (INIT_REFS > 1) ? $clog2(INIT_REFS) : 1;

    seq_state_e        state, state_nx;
    logic [CNT_W-1:0]  last_val;
    logic              phase_last;
    logic [REFN_W-1:0] ref_num;
    logic              last_init_ref;
    sdram_cmd_e        cmd;

    // Length of the current phase, as the final count value.
    always_comb begin
        unique case (state)
            ST_PAUSE:      last_val = CNT_W'(PAUSE_CYC - 1);
            ST_TRP:        last_val = CNT_W'(TRP_CYC - 1);
            ST_MRD:        last_val = CNT_W'(MRD_CYC - 1);
            ST_ITRC, ST_TRC: last_val = CNT_W'(TRC_CYC - 1);
            default:       last_val = '0;
        endcase
    end

    seq_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_val   (last_val),
        .phase_last (phase_last)
    );

    assign last_init_ref = (ref_num == REFN_W'(INIT_REFS - 1));

    // Next phase: advance only on the final cycle of the current phase.
    always_comb begin
        state_nx = state;
        if (phase_last) begin
            unique case (state)
                ST_PAUSE: state_nx = ST_PRE;
                ST_PRE:   state_nx = ST_TRP;
                ST_TRP:   state_nx = ST_MRS;
                ST_MRS:   state_nx = ST_MRD;
                ST_MRD:   state_nx = ST_IREF;
                ST_IREF:  state_nx = ST_ITRC;
                ST_ITRC:  state_nx = last_init_ref ? ST_IDLE : ST_IREF;
                ST_IDLE:  state_nx = (ref_req && ref_grant) ? ST_REF : ST_IDLE;
                ST_REF:   state_nx = ST_TRC;
                ST_TRC:   state_nx = ST_IDLE;
                default:  state_nx = ST_PAUSE;
            endcase
        end
    end

    // Phase register; reset restarts the full start-up sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
        end else begin
            state <= state_nx;
        end
    end

    // Start-up refresh counter, stepped at the end of each recovery gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_num <= '0;
        end else if (state == ST_ITRC && phase_last && !last_init_ref) begin
            ref_num <= ref_num + 1'b1;
        end
    end

    assign init_done = (state == ST_IDLE) || (state == ST_REF) || (state == ST_TRC);

    refresh_interval_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (init_done),
        .issue   (state == ST_REF),
        .ref_req (ref_req)
    );

    sdram_cmd_encode #(
        .ADDR_W      (ADDR_W),
        .BANK_W      (BANK_W),
        .PRE_ALL_BIT (10)
    ) u_enc (
        .state    (state),
        .mode_val (mode_val),
        .cmd      (cmd),
        .addr     (sd_addr),
        .ba       (sd_ba)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = 1'b1;
    assign sd_dqm = !init_done;

    assert_mrs_only_in_startup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> !init_done);

    assert_nop_after_mrs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

    assert_nop_after_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done));

    assert_refresh_was_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && cmd == CMD_REF) |-> $past(ref_req && ref_grant));

endmodule

// File: tb/tb_sdram_init_refresh_seq.sv
// Bench: a behavioural queue model predicts every cycle of the command bus,
// the flags and the request, and is compared with the design each clock.
module tb_sdram_init_refresh_seq;

    localparam int  CLK_PERIOD = 10;
    localparam int  AW         = 11;
    localparam int  PAUSE      = 16;
    localparam int  TRP        = 2;
    localparam int  MRD        = 2;
    localparam int  TRC        = 4;
    localparam int  NREF       = 8;
    localparam int  IVL        = 40;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mode_val = '0;
    logic          ref_grant = 1'b0;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm;
    logic [0:0]    sd_ba;
    logic [AW-1:0] sd_addr;
    logic          init_done, ref_req;

    int n_checks = 0;
    int n_fail   = 0;
    int n_run_refs = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    // Reference model state.
    logic [3:0]    q_cmd[$];
    logic [AW-1:0] q_addr[$];
    string         q_tag[$];
    bit            m_done = 1'b0;
    bit            m_req  = 1'b0;
    int            m_ivl  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_init_refresh_seq #(
        .ADDR_W(AW), .BANK_W(1), .PAUSE_CYC(PAUSE), .TRP_CYC(TRP),
        .MRD_CYC(MRD), .TRC_CYC(TRC), .INIT_REFS(NREF), .REF_INTERVAL(IVL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_val(mode_val), .ref_grant(ref_grant),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .init_done(init_done), .ref_req(ref_req)
    );

    task automatic push(input logic [3:0] c, input logic [AW-1:0] a, input string t);
        q_cmd.push_back(c);
        q_addr.push_back(a);
        q_tag.push_back(t);
    endtask

    task automatic build_startup();
        q_cmd.delete(); q_addr.delete(); q_tag.delete();
        for (int i = 0; i < PAUSE; i++) push(C_NOP, '0, "R1");
        push(C_PRE, AW'(1) << 10, "R2");
        for (int i = 0; i < TRP; i++) push(C_NOP, '0, "R2");
        push(C_MRS, mode_val, "R3");
        for (int i = 0; i < MRD; i++) push(C_NOP, '0, "R4");
        for (int r = 0; r < NREF; r++) begin
            push(C_REF, '0, "R5");
            for (int i = 0; i < TRC; i++) push(C_NOP, '0, "R5");
        end
    endtask

    // Model step at each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            build_startup();
            m_done = 1'b0;
            m_req  = 1'b0;
            m_ivl  = 0;
        end else begin
            bit tick, issue, req_nx;
            issue  = m_done && (q_cmd.size() > 0) && (q_cmd[0] == C_REF);
            tick   = m_done && (m_ivl == IVL - 1);
            m_ivl  = (!m_done || tick) ? 0 : m_ivl + 1;
            req_nx = tick ? 1'b1 : (issue ? 1'b0 : m_req);
            if (q_cmd.size() > 0) begin
                void'(q_cmd.pop_front());
                void'(q_addr.pop_front());
                void'(q_tag.pop_front());
                if (q_cmd.size() == 0) m_done = 1'b1;
            end else if (m_done && m_req && ref_grant) begin
                push(C_REF, '0, "R9");
                for (int i = 0; i < TRC; i++) push(C_NOP, '0, "R9");
            end
            m_req = req_nx;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare with the model a quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (chk_en) begin
            logic [3:0]    ecmd;
            logic [AW-1:0] eaddr;
            string         tag;
            logic [3:0]    acmd;
            acmd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            ecmd  = (q_cmd.size() > 0) ? q_cmd[0] : C_NOP;
            eaddr = (q_cmd.size() > 0) ? q_addr[0] : '0;
            tag   = (q_cmd.size() > 0) ? q_tag[0] : "R9 R11";
            check(acmd == ecmd, tag, "command", 32'(acmd), 32'(ecmd));
            check(sd_addr == eaddr && sd_ba == 1'b0, tag, "address/bank",
                  32'({sd_ba, sd_addr}), 32'(eaddr));
            check(sd_cke == 1'b1, "R7", "cke", 32'(sd_cke), 32'd1);
            check(init_done == m_done && sd_dqm == !m_done, "R6", "done/dqm",
                  32'({init_done, sd_dqm}), 32'({m_done, !m_done}));
            check(ref_req == m_req, "R8 R10", "ref_req", 32'(ref_req), 32'(m_req));
            if (init_done && acmd == C_REF) n_run_refs++;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // First start-up with one mode value (R1..R6); grant pulses ignored (R11).
        mode_val = 11'h032;
        rst_n = 1'b0;
        cycles(3);
        chk_en = 1'b1;
        cycles(1);
        rst_n = 1'b1;
        cycles(10);
        ref_grant = 1'b1; cycles(2); ref_grant = 1'b0;
        cycles(25);
        ref_grant = 1'b1; cycles(5); ref_grant = 1'b0;
        cycles(40);
        // Normal operation: grant while no request is pending (R11).
        ref_grant = 1'b1; cycles(3); ref_grant = 1'b0;
        // Grant held high: refresh follows each request (R8, R9, R10).
        cycles(20);
        ref_grant = 1'b1;
        cycles(150);
        // Grant withheld past a second expiry, then pulsed (R10).
        ref_grant = 1'b0;
        cycles(95);
        ref_grant = 1'b1; cycles(1); ref_grant = 1'b0;
        cycles(60);
        ref_grant = 1'b1; cycles(1); ref_grant = 1'b0;
        cycles(30);
        check(n_run_refs >= 4, "R9", "refreshes served", 32'(n_run_refs), 32'd4);
        // Reset mid-operation with another mode value: full restart (R1, R3).
        rst_n = 1'b0;
        cycles(1);
        mode_val = 11'h221;
        cycles(2);
        rst_n = 1'b1;
        ref_grant = 1'b1;
        cycles(180);
        ref_grant = 1'b0;
        cycles(5);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule